// File: doc/BRIEF.md
# Fractional-Rate SPI Serial Clock Generator

This block makes the master serial clock of an SPI controller from the 100 MHz system clock. A phase accumulator adds the programmed rate word on every system cycle, and every carry out of the accumulator marks a half-period boundary where the clock pin flips. The clock frequency is therefore rate × 100 / 4096 MHz. Rates that do not divide the system clock evenly produce half-periods of two neighbouring lengths, and the long-run average comes out right.

The transfer engine starts and stops the clock with `run`. Software enables the block and selects the idle polarity. The shift logic receives two one-cycle strobes that fire in the same cycle as the pin toggle. The leading strobe marks the edge away from the idle level and the trailing strobe marks the edge back to it. The rate word is loaded either directly or from a 16-entry table of preset rates chosen by a 4-bit code. The stored code is read back and is left alone by direct rate writes.

Top module: `sclk_phase_gen`

## Requirements
- R1: Over n consecutive running cycles at rate word w, the clock toggles exactly floor(n·w/2048) times, giving a frequency of w·100/4096 MHz at a 100 MHz system clock.
- R2: After reset the rate word reads 0x800 (50 MHz, one-cycle half-periods), the preset code reads 15, the clock is low and both strobes are low.
- R3: A direct rate write above 0x800 stores 0x800; the stored rate word never exceeds 0x800.
- R4: Every half-period lasts a whole number of system cycles, either floor(2048/w) or ceil(2048/w) cycles (for example 0x4CC gives 1- and 2-cycle phases, about 30 MHz).
- R5: Polarity 0 idles the clock low and its first edge rises; polarity 1 idles it high and its first edge falls.
- R6: Loading preset code c sets the rate word to round(f·40.96), where f for codes 0..15 is 0.025, 0.05, 0.1, 0.2, 0.5, 1, 1.25, 2, 2.5, 3.3333, 5, 10, 12.5, 16.6666, 25, 50 MHz (for example code 7 gives 82 and code 15 gives 2048).
- R7: A direct rate write leaves the preset code readback unchanged, so the code may no longer match the rate word.
- R8: While `enable` or `run` is low, the accumulator is cleared, the clock is at its idle level one cycle later and no strobe fires. After a start, the first toggle comes after exactly ceil(2048/w) running cycles.
- R9: Each toggle is marked by exactly one strobe, one cycle wide and in the same cycle as the pin change. It is the leading strobe when the pin leaves its idle level and the trailing strobe when it returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable |
| run | input | 1 | Start/stop request from the transfer engine |
| polarity | input | 1 | 0: idle low, 1: idle high |
| rate_wr | input | 1 | Load rate_din into the rate word |
| rate_din | input | 12 | Direct rate word, clamped to 0x800 |
| preset_wr | input | 1 | Load preset_din and its table rate |
| preset_din | input | 4 | Preset rate code |
| rate_word | output | 12 | Current rate word |
| preset_code | output | 4 | Last loaded preset code |
| sclk | output | 1 | Serial clock pin level |
| lead_stb | output | 1 | Pulse on the edge leaving idle |
| trail_stb | output | 1 | Pulse on the edge returning to idle |

## Verification
The hardest case to reach is proving that the accumulator really returns to zero on a stop. The pin is already idle, so a residue left in the accumulator cannot be seen at that point. The bench sets a slow rate of 3, where the first toggle falls at running cycle 683. It runs for 682 cycles, which leaves a residue just below the carry, then stops and restarts. It checks that no toggle appears before the full first half-period has passed again. Fractional rates such as 0x4CC are checked by bounding the shortest and longest observed phases, and by the exact toggle count over a long window.

// File: rtl/sclk_phase_gen.sv
module sclk_phase_gen #(
  parameter int ACC_W     = 12,
  parameter int SEL_W     = 4,
  parameter int RESET_SEL = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             run,
  input  logic             polarity,
  input  logic             rate_wr,
  input  logic [ACC_W-1:0] rate_din,
  input  logic             preset_wr,
  input  logic [SEL_W-1:0] preset_din,
  output logic [ACC_W-1:0] rate_word,
  output logic [SEL_W-1:0] preset_code,
  output logic             sclk,
  output logic             lead_stb,
  output logic             trail_stb
);

  localparam logic [ACC_W-1:0] MAX_WORD = ACC_W'(1) << (ACC_W - 1);

  function automatic logic [ACC_W-1:0] preset_word(input logic [SEL_W-1:0] code);
    logic [11:0] w;
    case (int'(code))
      0:  w = 12'd1;
      1:  w = 12'd2;
      2:  w = 12'd4;
      3:  w = 12'd8;
      4:  w = 12'd20;
      5:  w = 12'd41;
      6:  w = 12'd51;
      7:  w = 12'd82;
      8:  w = 12'd102;
      9:  w = 12'd137;
      10: w = 12'd205;
      11: w = 12'd410;
      12: w = 12'd512;
      13: w = 12'd683;
      14: w = 12'd1024;
      default: w = 12'd2048;
    endcase
    return ACC_W'(w) << (ACC_W - 12);
  endfunction

  logic [ACC_W-1:0] rate_q, acc_q;
  logic [SEL_W-1:0] sel_q;
  logic             sclk_q, lead_q, trail_q;

  wire             going   = enable & run;
  wire [ACC_W:0]   sum     = {1'b0, acc_q} + {rate_q, 1'b0};
  wire             carry   = sum[ACC_W];
  wire             at_idle = (sclk_q == polarity);
  wire [ACC_W-1:0] clamped = (rate_din > MAX_WORD) ? MAX_WORD : rate_din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= SEL_W'(RESET_SEL);
      rate_q <= preset_word(SEL_W'(RESET_SEL));
    end else if (preset_wr) begin
      sel_q  <= preset_din;
      rate_q <= preset_word(preset_din);
    end else if (rate_wr) begin
      rate_q <= clamped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      sclk_q  <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (!going) begin
      acc_q   <= '0;
      sclk_q  <= polarity;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      acc_q   <= sum[ACC_W-1:0];
      sclk_q  <= sclk_q ^ carry;
      lead_q  <= carry & at_idle;
      trail_q <= carry & ~at_idle;
    end
  end

  assign rate_word   = rate_q;
  assign preset_code = sel_q;
  assign sclk        = sclk_q;
  assign lead_stb    = lead_q;
  assign trail_stb   = trail_q;

endmodule

module sclk_phase_gen_chk #(
  parameter int ACC_W = 12,
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             run,
  input logic             polarity,
  input logic             rate_wr,
  input logic             preset_wr,
  input logic [ACC_W-1:0] rate_word,
  input logic [SEL_W-1:0] preset_code,
  input logic             sclk,
  input logic             lead_stb,
  input logic             trail_stb
);
  localparam logic [ACC_W-1:0] MAX_WORD = ACC_W'(1) << (ACC_W - 1);

  a_r3_rate_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    rate_word <= MAX_WORD);

  a_r7_code_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_wr && !preset_wr) |=> $stable(preset_code));

  a_r8_idle_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !(enable && run) |=> (sclk == $past(polarity)) && !lead_stb && !trail_stb);

  a_r9_strobe_on_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_stb || trail_stb) |-> (sclk != $past(sclk)));

  a_r9_toggle_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable && run) && (sclk != $past(sclk))) |-> (lead_stb || trail_stb));

  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_stb && trail_stb));

  a_r5_lead_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |-> (sclk != $past(polarity)));
endmodule

bind sclk_phase_gen sclk_phase_gen_chk #(.ACC_W(ACC_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .run(run), .polarity(polarity),
  .rate_wr(rate_wr), .preset_wr(preset_wr), .rate_word(rate_word),
  .preset_code(preset_code), .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
);

// File: tb/tb_sclk_phase_gen.sv
`timescale 1ns/1ps
module tb_sclk_phase_gen;
  logic clk = 0, rst_n = 0, enable = 0, run = 0, polarity = 0;
  logic rate_wr = 0, preset_wr = 0;
  logic [11:0] rate_din = '0;
  logic [3:0]  preset_din = '0;
  logic [11:0] rate_word;
  logic [3:0]  preset_code;
  logic sclk, lead_stb, trail_stb;

  sclk_phase_gen dut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit mon_on = 0, prev = 0;
  int tog, leads, trails, bad, since, pmin, pmax;

  always @(posedge clk) begin
    #2;
    if (mon_on) begin
      since++;
      if (sclk !== prev) begin
        bit exp_lead;
        exp_lead = (prev === polarity);
        tog++;
        if (exp_lead) leads++; else trails++;
        if (lead_stb !== exp_lead || trail_stb !== !exp_lead) bad++;
        if (since < pmin) pmin = since;
        if (since > pmax) pmax = since;
        since = 0;
      end else if (lead_stb || trail_stb) bad++;
      prev = sclk;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_rate(input logic [11:0] w);
    @(negedge clk); rate_din = w; rate_wr = 1;
    @(negedge clk); rate_wr = 0;
  endtask

  task automatic load_preset(input logic [3:0] c);
    @(negedge clk); preset_din = c; preset_wr = 1;
    @(negedge clk); preset_wr = 0;
  endtask

  task automatic window(input int n);
    @(negedge clk);
    tog = 0; leads = 0; trails = 0; bad = 0; since = 0; pmin = 1 << 30; pmax = 0;
    prev = sclk; mon_on = 1; run = 1;
    repeat (n) @(posedge clk);
    #3; mon_on = 0;
    @(negedge clk); run = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(sclk === 0, "R2", "sclk after reset", sclk, 0);
    chk(lead_stb === 0 && trail_stb === 0, "R2", "strobes after reset", lead_stb | trail_stb, 0);
    chk(rate_word === 12'h800, "R2", "rate word after reset", rate_word, 12'h800);
    chk(preset_code === 4'd15, "R2", "preset code after reset", preset_code, 15);
  endtask

  task automatic t_rate(input logic [11:0] w, input int n);
    int lo, hi, et;
    write_rate(w);
    et = (n * int'(w)) / 2048;
    lo = 2048 / int'(w);
    hi = (2048 + int'(w) - 1) / int'(w);
    window(n);
    chk(tog == et, "R1", "toggle count", tog, et);
    chk(leads == (et + 1) / 2, "R9", "leading strobes", leads, (et + 1) / 2);
    chk(trails == et / 2, "R9", "trailing strobes", trails, et / 2);
    chk(bad == 0, "R9", "strobe/toggle mismatches", bad, 0);
    chk(pmin >= lo, "R4", "shortest phase", pmin, lo);
    chk(pmax <= hi, "R4", "longest phase", pmax, hi);
  endtask

  task automatic t_clamp();
    write_rate(12'hFFF);
    chk(rate_word === 12'h800, "R3", "clamped 0xFFF", rate_word, 12'h800);
    write_rate(12'h801);
    chk(rate_word === 12'h800, "R3", "clamped 0x801", rate_word, 12'h800);
  endtask

  task automatic t_polarity();
    polarity = 1;
    @(negedge clk); @(negedge clk);
    chk(sclk === 1, "R5", "idle level polarity 1", sclk, 1);
    write_rate(12'h800);
    window(10);
    chk(tog == 10 && leads == 5 && bad == 0, "R5", "polarity 1 edges", leads, 5);
    chk(sclk === 1, "R5", "back to idle high", sclk, 1);
    polarity = 0;
    @(negedge clk); @(negedge clk);
    chk(sclk === 0, "R5", "idle level polarity 0", sclk, 0);
  endtask

  task automatic t_presets();
    real f[16] = '{0.025, 0.05, 0.1, 0.2, 0.5, 1.0, 1.25, 2.0,
                   2.5, 3.3333, 5.0, 10.0, 12.5, 16.6666, 25.0, 50.0};
    for (int c = 0; c < 16; c++) begin
      int ew;
      ew = $rtoi(f[c] * 4096.0 / 100.0 + 0.5);
      load_preset(4'(c));
      chk(rate_word == 12'(ew), "R6", $sformatf("preset %0d word", c), rate_word, ew);
      chk(preset_code == 4'(c), "R6", "preset code readback", preset_code, c);
    end
    load_preset(4'd7);
    write_rate(12'h4CC);
    chk(preset_code === 4'd7, "R7", "code after direct write", preset_code, 7);
    chk(rate_word === 12'h4CC, "R7", "word after direct write", rate_word, 12'h4CC);
    load_preset(4'd7);
    window(4096);
    chk(tog == 164, "R6", "preset 7 toggles", tog, 164);
  endtask

  task automatic t_stop();
    write_rate(12'h4CC);
    @(negedge clk); run = 1;
    repeat (7) @(negedge clk);
    run = 0;
    @(negedge clk);
    chk(sclk === polarity && !lead_stb && !trail_stb, "R8", "idle after stop", sclk, polarity);
    enable = 0;
    window(30);
    chk(tog == 0 && sclk === 0, "R8", "disabled toggles", tog, 0);
    enable = 1;
    write_rate(12'd3);
    window(682);
    chk(tog == 0, "R8", "no edge before 683 cycles", tog, 0);
    window(683);
    chk(tog == 1 && pmax == 683, "R8", "first edge after restart", pmax, 683);
    window(1);
    chk(tog == 0, "R8", "accumulator cleared on stop", tog, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    enable = 1;
    @(negedge clk);
    t_rate(12'h800, 64);
    t_rate(12'h4CC, 4096);
    t_rate(12'd1, 4096);
    t_rate(12'd683, 3000);
    t_clamp();
    t_polarity();
    t_presets();
    t_stop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule